// File: doc/BRIEF.md
# Per-Port Ownership Router for a Dual Host Controller

This block decides, one root port at a time, which of two host controllers drives that port: the high-speed controller or a legacy companion controller that serves full-speed and low-speed devices. From each controller's point of view the port looks like an ordinary port that gains and loses devices. A handoff is therefore presented as a disconnect on the side that gives the port up and as a connect on the side that takes it.

Software sets a global configured flag once the high-speed driver is running. While the flag is clear, every port belongs to the companion. When the flag is set, the high-speed side takes every port. Software can then hand a port that carries a slower device back to the companion with a per-port release request. When that device is unplugged, the port returns to the high-speed side. Each side has a connect status per port and a sticky change bit per port. Software clears a change bit by writing one to it.

The block has one cell per port, built by a generate loop. Inside each cell, one change tracker serves each controller side. A parameter selects the priority between a change being set and a clear in the same cycle.

Top module: `port_owner_router`

## Requirements
- R1: After reset every bit of `owner_cc` is 1 (companion owns), and all connect and change outputs are 0.
- R2: In the cycle after any cycle in which `cfg_flag` is 0, `owner_cc` is 1 on every port.
- R3: If `cfg_flag` is 1 in a cycle and was 0 in the previous cycle, then `owner_cc` is 0 on every port in the next cycle. Release requests and detaches in that cycle do not alter this.
- R4: With `cfg_flag` held at 1, a release request on a port has an effect only when all of the following hold: the port is owned by the high-speed side, a device is present, that device was attached with `hs_detect` = 0, and there is no detach in the same cycle. The effect is that `owner_cc` of that port becomes 1 on the next cycle and no other port's owner bit changes.
- R5: A release request on a port with no device present is ignored, and so is a release request on a port whose device was attached with `hs_detect` = 1. In both cases the owner bit stays 0 and no change bit is set.
- R6: On an honoured release, in the next cycle `hs_conn` becomes 0 and `hs_csc` becomes 1 for that port, and `cc_conn` and `cc_csc` both become 1.
- R7: With `cfg_flag` at 1, a detach on a companion-owned port returns the port to the high-speed side (`owner_cc` = 0) in the next cycle. The companion side sees a disconnect (`cc_csc` set), and `hs_conn` stays 0.
- R8: When `cfg_flag` falls, every port's owner bit becomes 1 in the next cycle. Any port that had a device owned by the high-speed side reports a disconnect there (`hs_conn` = 0, `hs_csc` = 1).
- R9: A change bit is set in the cycle after its side's connect status changes. It stays set until a 1 is written to its clear input. When a set and a clear fall in the same cycle, the set wins (default `CLEAR_WINS` = 0).
- R10: `hs_conn` is 1 exactly when a device is present and the high-speed side owns the port. `cc_conn` is 1 exactly when a device is present and the companion owns the port. An attach is reported on the owning side one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flag | input | 1 | Global configured flag from high-speed software |
| attach | input | NPORTS | One-cycle device attach event per port |
| detach | input | NPORTS | One-cycle device detach event per port (wins over attach) |
| hs_detect | input | NPORTS | Speed result, sampled with attach: 1 = high-speed device |
| release_req | input | NPORTS | Software request to hand the port to the companion |
| hs_csc_clr | input | NPORTS | Write-one-to-clear for the high-speed change bits |
| cc_csc_clr | input | NPORTS | Write-one-to-clear for the companion change bits |
| owner_cc | output | NPORTS | Owner per port: 1 = companion, 0 = high-speed |
| hs_conn | output | NPORTS | Connect status seen by the high-speed controller |
| hs_csc | output | NPORTS | Sticky connect-change bit, high-speed side |
| cc_conn | output | NPORTS | Connect status seen by the companion controller |
| cc_csc | output | NPORTS | Sticky connect-change bit, companion side |

## Verification
The hardest situation to reach is the full round trip on one port:
1. software sets the flag;
2. a slow device attaches;
3. the port is released;
4. the device detaches;
5. a fresh device arrives.

During this sequence, change bits must also be cleared at the same moment that new changes are set. Random port traffic rarely keeps a device on a port long enough for a release to land on it. The directed part therefore walks two ports through this round trip and through the ignored-release cases. A long random phase then biases attach, detach and release events per port. It toggles the flag only rarely, and every cycle is compared against a reference model of the requirements.

// File: rtl/portown_pkg.sv
package portown_pkg;
   typedef enum logic {
      OWNER_HS = 1'b0,
      OWNER_CC = 1'b1
   } owner_e;

   localparam int unsigned MAX_PORTS = 15;
endpackage

// File: rtl/portown_csc.sv
module portown_csc #(
   parameter bit CLEAR_WINS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic conn_now,
   input  logic conn_next,
   input  logic clr,
   output logic csc
);
   logic changed;
   logic csc_d;

   assign changed = conn_now ^ conn_next;

   generate
      if (CLEAR_WINS) begin : g_clear_wins
         assign csc_d = (csc | changed) & ~clr;
      end else begin : g_set_wins
         assign csc_d = (csc & ~clr) | changed;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) csc <= 1'b0;
      else        csc <= csc_d;
   end

   // R9: a change of the connect status leaves the change bit set
   p_change_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (conn_now != conn_next) && (!CLEAR_WINS || !clr) |=> csc);
   // R9: sticky until written
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (csc && !clr) |=> csc);
endmodule

// File: rtl/portown_cell.sv
module portown_cell
   import portown_pkg::*;
#(
   parameter bit CLEAR_WINS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg,
   input  logic cfg_rise,
   input  logic attach,
   input  logic detach,
   input  logic hs_det,
   input  logic rel,
   input  logic hs_clr,
   input  logic cc_clr,
   output logic owner_cc,
   output logic hs_conn,
   output logic hs_csc,
   output logic cc_conn,
   output logic cc_csc
);
   owner_e owner_q, owner_d;
   logic   present_q, present_d;
   logic   fast_q, fast_d;
   logic   rel_ok;
   logic   hs_conn_d, cc_conn_d;

   always_comb begin
      present_d = present_q;
      fast_d    = fast_q;
      if (detach) begin
         present_d = 1'b0;
      end else if (attach) begin
         present_d = 1'b1;
         fast_d    = hs_det;
      end
   end

   assign rel_ok = rel && present_q && !fast_q && !detach && (owner_q == OWNER_HS);

   always_comb begin
      owner_d = owner_q;
      if (!cfg)
         owner_d = OWNER_CC;
      else if (cfg_rise)
         owner_d = OWNER_HS;
      else if ((owner_q == OWNER_CC) && detach)
         owner_d = OWNER_HS;
      else if (rel_ok)
         owner_d = OWNER_CC;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q   <= OWNER_CC;
         present_q <= 1'b0;
         fast_q    <= 1'b0;
      end else begin
         owner_q   <= owner_d;
         present_q <= present_d;
         fast_q    <= fast_d;
      end
   end

   assign owner_cc  = (owner_q == OWNER_CC);
   assign hs_conn   = present_q && (owner_q == OWNER_HS);
   assign cc_conn   = present_q && (owner_q == OWNER_CC);
   assign hs_conn_d = present_d && (owner_d == OWNER_HS);
   assign cc_conn_d = present_d && (owner_d == OWNER_CC);

   portown_csc #(.CLEAR_WINS(CLEAR_WINS)) u_hs_csc (
      .clk(clk), .rst_n(rst_n), .conn_now(hs_conn), .conn_next(hs_conn_d),
      .clr(hs_clr), .csc(hs_csc));

   portown_csc #(.CLEAR_WINS(CLEAR_WINS)) u_cc_csc (
      .clk(clk), .rst_n(rst_n), .conn_now(cc_conn), .conn_next(cc_conn_d),
      .clr(cc_clr), .csc(cc_csc));

   p_cfg_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg |=> owner_cc);
   p_cfg_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rise |=> !owner_cc);
   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg && !cfg_rise && !owner_cc && rel && hs_conn && !fast_q && !detach) |=> owner_cc);
   p_keep_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg && !owner_cc && rel && fast_q && !attach) |=> !owner_cc);
   p_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg && !cfg_rise && !owner_cc && rel && hs_conn && !fast_q && !detach)
      |=> (hs_csc && cc_csc && cc_conn && !hs_conn));
   p_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg && !cfg_rise && owner_cc && detach) |=> (!owner_cc && !hs_conn));
   p_cfg_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg && hs_conn && !detach) |=> (hs_csc && !hs_conn));
   p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_conn && cc_conn));
endmodule

// File: rtl/port_owner_router.sv
module port_owner_router
   import portown_pkg::*;
#(
   parameter int unsigned NPORTS     = 4,
   parameter bit          CLEAR_WINS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_flag,
   input  logic [NPORTS-1:0] attach,
   input  logic [NPORTS-1:0] detach,
   input  logic [NPORTS-1:0] hs_detect,
   input  logic [NPORTS-1:0] release_req,
   input  logic [NPORTS-1:0] hs_csc_clr,
   input  logic [NPORTS-1:0] cc_csc_clr,
   output logic [NPORTS-1:0] owner_cc,
   output logic [NPORTS-1:0] hs_conn,
   output logic [NPORTS-1:0] hs_csc,
   output logic [NPORTS-1:0] cc_conn,
   output logic [NPORTS-1:0] cc_csc
);
   initial begin
      assert (NPORTS >= 1 && NPORTS <= MAX_PORTS)
         else $error("NPORTS out of range");
   end

   logic cfg_q;
   logic cfg_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_q <= 1'b0;
      else        cfg_q <= cfg_flag;
   end

   assign cfg_rise = cfg_flag && !cfg_q;

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      portown_cell #(.CLEAR_WINS(CLEAR_WINS)) u_cell (
         .clk(clk), .rst_n(rst_n), .cfg(cfg_flag), .cfg_rise(cfg_rise),
         .attach(attach[p]), .detach(detach[p]), .hs_det(hs_detect[p]),
         .rel(release_req[p]), .hs_clr(hs_csc_clr[p]), .cc_clr(cc_csc_clr[p]),
         .owner_cc(owner_cc[p]), .hs_conn(hs_conn[p]), .hs_csc(hs_csc[p]),
         .cc_conn(cc_conn[p]), .cc_csc(cc_csc[p]));
   end

   // R4: a release touches at most one port per requested port
   p_release_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flag && cfg_q && (detach == '0)) |=> ((owner_cc & ~$past(owner_cc) & ~$past(release_req)) == '0));
endmodule

// File: tb/sim_port_owner_router.sv
`timescale 1ns/1ps
module sim_port_owner_router;
   localparam int NP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_flag = 1'b0;
   logic [NP-1:0] attach = '0, detach = '0, hs_detect = '0, release_req = '0;
   logic [NP-1:0] hs_csc_clr = '0, cc_csc_clr = '0;
   logic [NP-1:0] owner_cc, hs_conn, hs_csc, cc_conn, cc_csc;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [NP-1:0] m_own, m_pres, m_fast, m_hcsc, m_ccsc;
   logic m_cfgq;

   always #5 clk = ~clk;

   port_owner_router #(.NPORTS(NP)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_flag(cfg_flag), .attach(attach), .detach(detach),
      .hs_detect(hs_detect), .release_req(release_req), .hs_csc_clr(hs_csc_clr),
      .cc_csc_clr(cc_csc_clr), .owner_cc(owner_cc), .hs_conn(hs_conn), .hs_csc(hs_csc),
      .cc_conn(cc_conn), .cc_csc(cc_csc));

   task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_own = '1; m_pres = '0; m_fast = '0; m_hcsc = '0; m_ccsc = '0; m_cfgq = 1'b0;
   endtask

   task automatic model_step();
      logic [NP-1:0] pn, fn, on;
      for (int p = 0; p < NP; p++) begin
         pn[p] = detach[p] ? 1'b0 : (attach[p] ? 1'b1 : m_pres[p]);
         fn[p] = (attach[p] && !detach[p]) ? hs_detect[p] : m_fast[p];
         if (!cfg_flag) on[p] = 1'b1;
         else if (!m_cfgq) on[p] = 1'b0;
         else if (m_own[p] && detach[p]) on[p] = 1'b0;
         else if (!m_own[p] && release_req[p] && m_pres[p] && !m_fast[p] && !detach[p]) on[p] = 1'b1;
         else on[p] = m_own[p];
         m_hcsc[p] = (m_hcsc[p] & ~hs_csc_clr[p]) | ((pn[p] & ~on[p]) ^ (m_pres[p] & ~m_own[p]));
         m_ccsc[p] = (m_ccsc[p] & ~cc_csc_clr[p]) | ((pn[p] & on[p]) ^ (m_pres[p] & m_own[p]));
      end
      m_pres = pn; m_fast = fn; m_own = on; m_cfgq = cfg_flag;
   endtask

   task automatic compare_all(input string tag);
      check({tag, " owner R2/R3/R4/R5/R7/R8"}, owner_cc, m_own);
      check({tag, " hs_conn R10"}, hs_conn, m_pres & ~m_own);
      check({tag, " cc_conn R10"}, cc_conn, m_pres & m_own);
      check({tag, " hs_csc R6/R9"}, hs_csc, m_hcsc);
      check({tag, " cc_csc R6/R9"}, cc_csc, m_ccsc);
   endtask

   // inputs are set at a falling edge; one clock; outputs sampled 1 ns later
   task automatic cyc();
      @(posedge clk);
      model_step();
      #1;
      @(negedge clk);
      attach = '0; detach = '0; release_req = '0; hs_csc_clr = '0; cc_csc_clr = '0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 owner", owner_cc, '1);
      check("R1 hs_conn", hs_conn, '0);
      check("R1 cc_conn", cc_conn, '0);
      check("R1 csc", hs_csc | cc_csc, '0);

      // device on port 3 before software: companion sees it
      attach = 4'b1000; cyc();
      check("R10 cc attach", cc_conn, 4'b1000);
      check("R2 owner", owner_cc, 4'b1111);
      cc_csc_clr = 4'b1000; cyc();
      check("R9 clear", cc_csc, 4'b0000);

      // software up: all ports to high-speed
      cfg_flag = 1'b1; release_req = 4'b1000; cyc();
      check("R3 owner", owner_cc, 4'b0000);
      check("R3 handoff hs", hs_conn, 4'b1000);
      check("R3 handoff cc", cc_csc, 4'b1000);
      hs_csc_clr = '1; cc_csc_clr = '1; cyc();

      // high-speed device port 0, full-speed device port 1
      attach = 4'b0011; hs_detect = 4'b0001; cyc();
      check("R10 hs attach", hs_conn, 4'b1011);
      check("R10 hs csc", hs_csc, 4'b0011);
      hs_csc_clr = '1; cyc();

      // release on high-speed device and empty port: ignored
      release_req = 4'b0101; cyc();
      check("R5 owner", owner_cc, 4'b0000);
      check("R5 csc", hs_csc | cc_csc, 4'b0000);

      // release of port 1: only port 1 moves
      release_req = 4'b0010; cyc();
      check("R4 owner", owner_cc, 4'b0010);
      check("R6 hs_conn", hs_conn, 4'b1001);
      check("R6 hs_csc", hs_csc, 4'b0010);
      check("R6 cc_conn", cc_conn, 4'b0010);
      check("R6 cc_csc", cc_csc, 4'b0010);

      // clear while a new change sets: set wins (R9)
      cc_csc_clr = 4'b0010; detach = 4'b0010; cyc();
      check("R7 owner", owner_cc, 4'b0000);
      check("R7 hs_conn", hs_conn, 4'b1001);
      check("R9 set wins", cc_csc, 4'b0010);
      hs_csc_clr = '1; cc_csc_clr = '1; cyc();
      check("R9 cleared", hs_csc | cc_csc, 4'b0000);

      // software gone: all to companion, high-speed disconnects
      cfg_flag = 1'b0; cyc();
      check("R8 owner", owner_cc, 4'b1111);
      check("R8 hs_conn", hs_conn, 4'b0000);
      check("R8 hs_csc", hs_csc, 4'b1001);
      check("R8 cc_conn", cc_conn, 4'b1001);
      compare_all("directed");

      // random phase against the model
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 60 == 0) cfg_flag = ~cfg_flag;
         for (int p = 0; p < NP; p++) begin
            attach[p]      = ($urandom % 7 == 0);
            detach[p]      = ($urandom % 11 == 0);
            hs_detect[p]   = $urandom % 2;
            release_req[p] = ($urandom % 4 == 0);
            hs_csc_clr[p]  = ($urandom % 3 == 0);
            cc_csc_clr[p]  = ($urandom % 3 == 0);
         end
         cyc();
         compare_all("random");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule